// File: doc/BRIEF.md
# Operand Readiness Scoreboard

This block sits beside the issue stage of an in-order integer/floating-point pipeline and answers one question each cycle: may the candidate instruction read its two source registers now? When an instruction issues, the scoreboard records its producer class against its destination register and starts counting the cycles since issue. A later candidate supplies its own consumer class and two source register numbers. The scoreboard turns each source into a ready flag from the producer class, the consumer class and the elapsed count.

How long a result takes to become usable depends on the pair of classes. Each producer class has a default latency. Some producer/consumer pairs are shortened by bypasses. The data operand of a store has its own, usually shorter, latency. A store needs only its address operand ready to issue. An instruction issuing in the same cycle as the candidate is seen by the candidate with zero cycles elapsed, which allows same-cycle store-data bypassing. Register 31 reads as constant zero and is never pending.

Top module: `op_ready_scoreboard`

## Requirements
- R1: After reset every register is ready for every consumer class.
- R2: A source written by a producer that issued k cycles before the candidate's cycle (k=0 when both are in the same cycle) is ready exactly when k is at least the pair's latency L. It is not ready for any k below L.
- R3: Default latencies by producer code: 0 add/logic 2, 1 shift/cmov 2, 2 compare 2, 3 mul32 21, 4 mul64 23, 5 FP arithmetic 6, 6 div single 34, 7 div double 63, 8 load 1, 9 branch/call 2, 10 barrier 4.
- R4: An add/logic producer is usable after 1 cycle by consumer codes 0 branch, 1 add/logic, 2 shift/cmov, 3 compare and 4 multiply.
- R5: A compare producer is usable after 1 cycle by a branch consumer (code 0).
- R6: For a store consumer (code 6), source B is the data operand. It is usable after 0 cycles from add/logic, shift/cmov and compare producers.
- R7: As store data, mul32 results need 20 cycles and mul64 results need 22 cycles.
- R8: An FP arithmetic producer is usable after 4 cycles by an FP arithmetic consumer (code 5).
- R9: For a store, `cand_issue_ok` follows source A (address) alone. For every other consumer class, including codes 5 and 7 (other), it needs both sources ready.
- R10: Register 31 is always ready. An issue that targets it creates no pending entry.
- R11: A newer issue to a register replaces the tracking of the older one.
- R12: Reserved producer codes 11 to 15 have latency 1 for every consumer.
- R13: An issue to one register leaves the readiness of all other registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_valid | input | 1 | An instruction issues this cycle |
| iss_dst | input | 5 | Destination register of the issuing instruction |
| iss_cls | input | 4 | Producer class code of the issuing instruction |
| cand_cls | input | 3 | Consumer class code of the candidate |
| cand_src_a | input | 5 | Candidate source A (address for a store) |
| cand_src_b | input | 5 | Candidate source B (data for a store) |
| cand_a_ready | output | 1 | Source A usable this cycle |
| cand_b_ready | output | 1 | Source B usable this cycle |
| cand_issue_ok | output | 1 | Candidate's operands permit issue |

## Verification
Every one of the 16 producer codes is paired with every one of the 8 consumer codes. For each pair, both ready flags and the issue flag are checked on every cycle from the issue cycle up to one past the expected latency. This finds off-by-one errors at each latency edge and a bypass applied to the wrong pair. It also shows whether the store-data latency is kept apart from the address latency. Directed sequences cover the zero register, replacement of an older pending producer, and isolation between registers.

// File: rtl/sb_pkg.sv
// Shared class codes and the producer/consumer latency function for the
// operand readiness scoreboard. Assumes latencies fit in LAT_W bits.
package sb_pkg;
    localparam int LAT_W  = 6;
    localparam int PCLS_W = 4;
    localparam int CCLS_W = 3;

    // producer class codes
    localparam logic [PCLS_W-1:0] P_ADDLOG  = 4'd0;
    localparam logic [PCLS_W-1:0] P_SHIFT   = 4'd1;
    localparam logic [PCLS_W-1:0] P_ICMP    = 4'd2;
    localparam logic [PCLS_W-1:0] P_MUL32   = 4'd3;
    localparam logic [PCLS_W-1:0] P_MUL64   = 4'd4;
    localparam logic [PCLS_W-1:0] P_FPOP    = 4'd5;
    localparam logic [PCLS_W-1:0] P_DIVS    = 4'd6;
    localparam logic [PCLS_W-1:0] P_DIVD    = 4'd7;
    localparam logic [PCLS_W-1:0] P_LOAD    = 4'd8;
    localparam logic [PCLS_W-1:0] P_BRANCH  = 4'd9;
    localparam logic [PCLS_W-1:0] P_BARRIER = 4'd10;

    // consumer class codes
    localparam logic [CCLS_W-1:0] C_BRANCH = 3'd0;
    localparam logic [CCLS_W-1:0] C_ADDLOG = 3'd1;
    localparam logic [CCLS_W-1:0] C_SHIFT  = 3'd2;
    localparam logic [CCLS_W-1:0] C_ICMP   = 3'd3;
    localparam logic [CCLS_W-1:0] C_MUL    = 3'd4;
    localparam logic [CCLS_W-1:0] C_FPOP   = 3'd5;
    localparam logic [CCLS_W-1:0] C_STORE  = 3'd6;
    localparam logic [CCLS_W-1:0] C_OTHER  = 3'd7;

    // Cycles after producer issue before the consumer may read the result.
    function automatic logic [LAT_W-1:0] lat_of(
        input logic [PCLS_W-1:0] p,
        input logic [CCLS_W-1:0] c,
        input logic              store_data
    );
        logic [LAT_W-1:0] l;
        case (p)
            P_ADDLOG, P_SHIFT, P_ICMP, P_BRANCH: l = LAT_W'(2);
            P_MUL32:   l = LAT_W'(21);
            P_MUL64:   l = LAT_W'(23);
            P_FPOP:    l = LAT_W'(6);
            P_DIVS:    l = LAT_W'(34);
            P_DIVD:    l = LAT_W'(63);
            P_BARRIER: l = LAT_W'(4);
            default:   l = LAT_W'(1);
        endcase
        if (store_data && c == C_STORE) begin
            if (p == P_ADDLOG || p == P_SHIFT || p == P_ICMP) l = LAT_W'(0);
            else if (p == P_MUL32) l = LAT_W'(20);
            else if (p == P_MUL64) l = LAT_W'(22);
        end else begin
            if (p == P_ADDLOG && c <= C_MUL) l = LAT_W'(1);
            else if (p == P_ICMP && c == C_BRANCH) l = LAT_W'(1);
            else if (p == P_FPOP && c == C_FPOP) l = LAT_W'(4);
        end
        return l;
    endfunction
endpackage

// File: rtl/sb_entry.sv
// One register's pending-result tracker: a busy flag, the producer class
// and a saturating count of cycles since issue. Assumes CNT_W bits can
// hold the largest latency; the entry retires when the count saturates.
module sb_entry #(
    parameter int CNT_W  = 6,
    parameter int PCLS_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set,
    input  logic [PCLS_W-1:0] set_cls,
    output logic              busy,
    output logic [PCLS_W-1:0] cls,
    output logic [CNT_W-1:0]  elapsed
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // Record a new producer or advance / retire the pending one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            cls     <= '0;
            elapsed <= '0;
        end else if (set) begin
            busy    <= 1'b1;
            cls     <= set_cls;
            elapsed <= CNT_W'(1);
        end else if (busy) begin
            if (elapsed == CNT_MAX) busy <= 1'b0;
            else                    elapsed <= elapsed + CNT_W'(1);
        end
    end

    AST_SET_STARTS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> (busy && elapsed == CNT_W'(1))); // R2
    AST_COUNT_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !set && elapsed != CNT_MAX) |=>
        (busy && elapsed == $past(elapsed) + CNT_W'(1))); // R2
    AST_RETIRES_AT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !set && elapsed == CNT_MAX) |=> !busy); // R2
endmodule

// File: rtl/sb_ready_eval.sv
// Turns one source's pending state into a ready flag for the given
// consumer class. Assumes elapsed is zero for a same-cycle producer.
module sb_ready_eval
    import sb_pkg::*;
(
    input  logic              pend,
    input  logic [PCLS_W-1:0] cls,
    input  logic [LAT_W-1:0]  elapsed,
    input  logic [CCLS_W-1:0] cons,
    input  logic              store_data,
    output logic              ready
);
    // Ready when nothing is pending or the pair's latency has elapsed.
    always_comb ready = !pend || (elapsed >= lat_of(cls, cons, store_data));
endmodule

// File: rtl/op_ready_scoreboard.sv
// Operand readiness scoreboard. Keeps one tracker per register (except
// the zero register) and evaluates two candidate sources per cycle.
// Assumes in-order issue: the newest issue to a register is its producer.
module op_ready_scoreboard
    import sb_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int ZERO_REG = NUM_REGS - 1,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_valid,
    input  logic [IDX_W-1:0]  iss_dst,
    input  logic [PCLS_W-1:0] iss_cls,
    input  logic [CCLS_W-1:0] cand_cls,
    input  logic [IDX_W-1:0]  cand_src_a,
    input  logic [IDX_W-1:0]  cand_src_b,
    output logic              cand_a_ready,
    output logic              cand_b_ready,
    output logic              cand_issue_ok
);
    localparam logic [IDX_W-1:0] ZERO_IDX = IDX_W'(ZERO_REG);
    localparam int NPORT = 2;

    logic              busy_v [NUM_REGS];
    logic [PCLS_W-1:0] cls_v  [NUM_REGS];
    logic [LAT_W-1:0]  el_v   [NUM_REGS];

    // one tracker per register; the zero register is tied idle
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        if (i == ZERO_REG) begin : g_zero
            assign busy_v[i] = 1'b0;
            assign cls_v[i]  = '0;
            assign el_v[i]   = '0;
        end else begin : g_trk
            sb_entry #(.CNT_W(LAT_W), .PCLS_W(PCLS_W)) u_entry (
                .clk     (clk),
                .rst_n   (rst_n),
                .set     (iss_valid && iss_dst == IDX_W'(i)),
                .set_cls (iss_cls),
                .busy    (busy_v[i]),
                .cls     (cls_v[i]),
                .elapsed (el_v[i])
            );
        end
    end

    logic [IDX_W-1:0] src   [NPORT];
    logic             rdy   [NPORT];
    assign src[0] = cand_src_a;
    assign src[1] = cand_src_b;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        logic              pend;
        logic [PCLS_W-1:0] pcls;
        logic [LAT_W-1:0]  pel;

        // Select the same-cycle issue if it targets this source, else the tracker.
        always_comb begin
            if (iss_valid && iss_dst == src[p] && src[p] != ZERO_IDX) begin
                pend = 1'b1;
                pcls = iss_cls;
                pel  = '0;
            end else begin
                pend = busy_v[src[p]];
                pcls = cls_v[src[p]];
                pel  = el_v[src[p]];
            end
        end

        sb_ready_eval u_eval (
            .pend       (pend),
            .cls        (pcls),
            .elapsed    (pel),
            .cons       (cand_cls),
            .store_data (p == 1),
            .ready      (rdy[p])
        );
    end

    assign cand_a_ready  = rdy[0];
    assign cand_b_ready  = rdy[1];
    // Store issue waits on the address only; others need both operands.
    assign cand_issue_ok = rdy[0] && (cand_cls == C_STORE || rdy[1]);

    AST_ZERO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (cand_src_a == ZERO_IDX) |-> cand_a_ready); // R10
    AST_SAME_SRC_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
        (cand_cls != C_STORE && cand_src_a == cand_src_b) |->
        (cand_a_ready == cand_b_ready)); // R2
    AST_DATA_NOT_LATER: assert property (@(posedge clk) disable iff (!rst_n)
        (cand_cls == C_STORE && cand_src_a == cand_src_b && cand_a_ready) |->
        cand_b_ready); // R6
    AST_FRESH_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_dst == cand_src_a && cand_src_a != ZERO_IDX) |->
        !cand_a_ready); // R2
endmodule

// File: tb/op_ready_scoreboard_test.sv
`timescale 1ns/1ps
module op_ready_scoreboard_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       iss_valid = 1'b0;
    logic [4:0] iss_dst = '0;
    logic [3:0] iss_cls = '0;
    logic [2:0] cand_cls = '0;
    logic [4:0] cand_src_a = '0;
    logic [4:0] cand_src_b = '0;
    logic       cand_a_ready, cand_b_ready, cand_issue_ok;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 0;

    always #10 clk = ~clk;

    op_ready_scoreboard uut (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_dst(iss_dst),
        .iss_cls(iss_cls), .cand_cls(cand_cls), .cand_src_a(cand_src_a),
        .cand_src_b(cand_src_b), .cand_a_ready(cand_a_ready),
        .cand_b_ready(cand_b_ready), .cand_issue_ok(cand_issue_ok)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 200000 && !done) begin
            failures++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string req, input logic act, input logic exp, input string ctx);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0b expected=%0b", req, ctx, act, exp);
        end
    endtask

    // latency from the requirement text
    function automatic int exp_lat(input int p, input int c, input bit data);
        int base;
        if (p <= 2 || p == 9) base = 2;
        else if (p == 3) base = 21;
        else if (p == 4) base = 23;
        else if (p == 5) base = 6;
        else if (p == 6) base = 34;
        else if (p == 7) base = 63;
        else if (p == 10) base = 4;
        else base = 1;
        if (data && c == 6) begin
            if (p <= 2) return 0;
            if (p == 3) return 20;
            if (p == 4) return 22;
            return base;
        end
        if (p == 0 && c <= 4) return 1;
        if (p == 2 && c == 0) return 1;
        if (p == 5 && c == 5) return 4;
        return base;
    endfunction

    function automatic string tag_of(input int p, input int c, input bit data);
        if (data && c == 6 && p <= 2) return "R6";
        if (data && c == 6 && (p == 3 || p == 4)) return "R7";
        if (!data && p == 0 && c <= 4) return "R4";
        if (!data && p == 2 && c == 0) return "R5";
        if (!data && p == 5 && c == 5) return "R8";
        if (p >= 11) return "R12";
        return "R3";
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: all registers idle after reset
        @(negedge clk);
        cand_cls = 3'd1;
        for (int r = 0; r < 32; r++) begin
            cand_src_a = 5'(r); cand_src_b = 5'(r);
            #1;
            chk("R1", cand_a_ready && cand_b_ready, 1'b1, $sformatf("reg %0d", r));
        end

        // R2..R9, R12: full producer x consumer sweep on register 5
        for (int p = 0; p < 16; p++) begin
            for (int c = 0; c < 8; c++) begin
                int la, lb, lmax;
                la = exp_lat(p, c, 0);
                lb = exp_lat(p, c, 1);
                lmax = (la > lb) ? la : lb;
                @(negedge clk);
                iss_valid = 1'b1; iss_dst = 5'd5; iss_cls = 4'(p);
                cand_cls = 3'(c); cand_src_a = 5'd5; cand_src_b = 5'd5;
                for (int k = 0; k <= lmax + 1; k++) begin
                    if (k > 0) begin
                        @(negedge clk);
                        iss_valid = 1'b0;
                    end
                    #2;
                    chk(tag_of(p, c, 0), cand_a_ready, k >= la,
                        $sformatf("R2 src A p=%0d c=%0d k=%0d", p, c, k));
                    chk(tag_of(p, c, 1), cand_b_ready, k >= lb,
                        $sformatf("R2 src B p=%0d c=%0d k=%0d", p, c, k));
                    chk("R9", cand_issue_ok, (k >= la) && (c == 6 || k >= lb),
                        $sformatf("issue p=%0d c=%0d k=%0d", p, c, k));
                end
            end
        end

        // R10: writes to register 31 never pend
        @(negedge clk);
        iss_valid = 1'b1; iss_dst = 5'd31; iss_cls = 4'd7;
        cand_cls = 3'd1; cand_src_a = 5'd31; cand_src_b = 5'd31;
        #2;
        chk("R10", cand_a_ready && cand_b_ready, 1'b1, "zero reg same cycle");
        @(negedge clk);
        iss_valid = 1'b0;
        #2;
        chk("R10", cand_a_ready && cand_b_ready, 1'b1, "zero reg next cycle");

        // R11: newer load replaces older double divide on register 7
        @(negedge clk);
        iss_valid = 1'b1; iss_dst = 5'd7; iss_cls = 4'd7;
        cand_cls = 3'd7; cand_src_a = 5'd7; cand_src_b = 5'd7;
        @(negedge clk);
        iss_cls = 4'd8;
        #2;
        chk("R11", cand_a_ready, 1'b0, "replacing load same cycle");
        @(negedge clk);
        iss_valid = 1'b0;
        #2;
        chk("R11", cand_a_ready, 1'b1, "replacing load after 1 cycle");

        // R13: divide into register 3 leaves register 4 ready
        @(negedge clk);
        iss_valid = 1'b1; iss_dst = 5'd3; iss_cls = 4'd7;
        cand_cls = 3'd1; cand_src_a = 5'd4; cand_src_b = 5'd3;
        @(negedge clk);
        iss_valid = 1'b0;
        #2;
        chk("R13", cand_a_ready, 1'b1, "neighbour register");
        chk("R13", cand_b_ready, 1'b0, "divided register still pending");
        chk("R9", cand_issue_ok, 1'b0, "non-store needs both");
        cand_cls = 3'd6; cand_src_a = 5'd4;
        #1;
        chk("R9", cand_issue_ok, 1'b1, "store waits on address only");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule